// File: doc/BRIEF.md
# Float/Integer Conversion Operand Screen

This block sits ahead of a floating-point/integer conversion unit. It checks the source operand before the conversion writes anything back. The source can be a single-precision float or a double-precision float going to an integer, or a 64-bit signed integer going to a float. The block decodes the operand class straight from the exponent and fraction fields. It raises an unimplemented cause when the hardware cannot handle the operand, and a write-block that suppresses the destination write in that case.

For float sources that pass the screen, the block also decides whether the rounded integer will differ from the source. This is true exactly when the source has a nonzero fractional part. Such a source raises the inexact cause, whatever the rounding mode or ceiling variant. When the inexact enable is clear, the block also pulses an inexact flag-set output so the sticky flag can be updated. All outputs are registered one stage after the request.

Top module: `cvt_screen`

## Requirements
- R1: After reset, and while in reset, `valid_o`, `cause_o`, `block_o` and `flag_inexact_o` are all zero.
- R2: `valid_o` is high exactly one cycle after a cycle with `valid_i` high. When `valid_o` is low, `cause_o`, `block_o` and `flag_inexact_o` are zero.
- R3: A float source with an all-ones exponent (infinity or NaN), or a zero exponent with a nonzero fraction (subnormal), raises the unimplemented cause.
- R4: A float source of plus or minus zero raises no cause.
- R5: A normal single source (`kind_i`=0, operand in `src_i[31:0]`) whose magnitude is 2^31 or more raises the unimplemented cause. This covers values at or above 2147483648.0 and at or below -2147483648.0.
- R6: A normal double source (`kind_i`=1) whose magnitude is 2^53 or more raises the unimplemented cause.
- R7: A 64-bit signed integer source (`kind_i`=2 or 3) raises the unimplemented cause when it is at or above 2^55, or below -2^55. A value of exactly -2^55 passes.
- R8: An in-range normal float source with a nonzero fractional part raises the inexact cause. An integral source does not.
- R9: `flag_inexact_o` is high in the same cycle as the inexact cause, but only if `inexact_en_i` was low with the request.
- R10: `cause_o` is one-hot or zero, with bit 0 for inexact and bit 1 for unimplemented. Unimplemented takes precedence. `block_o` is high exactly when bit 1 is set.
- R11: An in-range integer source raises no cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request strobe |
| kind_i | input | 2 | Source format: 0 single, 1 double, 2/3 int64 |
| src_i | input | 64 | Source operand bits |
| inexact_en_i | input | 1 | Inexact trap enable from control register |
| valid_o | output | 1 | Result strobe, one cycle after request |
| cause_o | output | 2 | Cause vector: bit 0 inexact, bit 1 unimplemented |
| block_o | output | 1 | Suppress destination write |
| flag_inexact_o | output | 1 | Set the sticky inexact flag |

## Verification
Every result is due one clock edge after its request. The bench drives a request on a falling edge and checks the outputs on the next falling edge, after the single rising edge that registers them. Back-to-back requests are applied on consecutive falling edges, so each check sees only its own request. The expected cause and flag come from bench functions that widen the source to a real value and compare it with the limits and with its floor.

// File: rtl/cvt_screen_pkg.sv
package cvt_screen_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_SUB  = 3'd1,
    CLS_NORM = 3'd2,
    CLS_INF  = 3'd3,
    CLS_NAN  = 3'd4
  } fp_class_e;

  typedef enum logic [1:0] {
    KIND_SP  = 2'd0,
    KIND_DP  = 2'd1,
    KIND_I64 = 2'd2,
    KIND_I64B = 2'd3
  } src_kind_e;

  localparam int unsigned CAUSE_W   = 2;
  localparam int unsigned CAUSE_INX = 0;
  localparam int unsigned CAUSE_UNI = 1;

  typedef struct packed {
    logic unimpl;
    logic inexact;
  } verdict_t;
endpackage

// File: rtl/cvt_float_screen.sv
module cvt_float_screen
  import cvt_screen_pkg::*;
#(
  parameter int unsigned EXP_W   = 8,
  parameter int unsigned FRAC_W  = 23,
  parameter int unsigned LIM_EXP = 31
) (
  input  logic [EXP_W+FRAC_W:0] val_i,
  output fp_class_e             cls_o,
  output verdict_t              verdict_o
);
  localparam int unsigned BIAS     = (1 << (EXP_W - 1)) - 1;
  localparam int unsigned LIM_BEXP = BIAS + LIM_EXP;
  localparam logic [EXP_W-1:0] BIAS_V = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] LIM_V  = EXP_W'(LIM_BEXP);
  localparam logic [EXP_W-1:0] FW_V   = EXP_W'(FRAC_W);

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic [EXP_W-1:0]  ipos;
  logic [FRAC_W-1:0] frac_mask;
  logic              range_err;
  logic              has_frac;

  assign exp_f  = val_i[EXP_W+FRAC_W-1:FRAC_W];
  assign frac_f = val_i[FRAC_W-1:0];

  always_comb begin
    if (&exp_f)       cls_o = (|frac_f) ? CLS_NAN : CLS_INF;
    else if (~|exp_f) cls_o = (|frac_f) ? CLS_SUB : CLS_ZERO;
    else              cls_o = CLS_NORM;
  end

  assign range_err = (cls_o == CLS_NORM) && (exp_f >= LIM_V);

  // fraction bits below the binary point
  always_comb begin
    ipos      = exp_f - BIAS_V;
    frac_mask = {FRAC_W{1'b1}} >> ipos;
    if (exp_f < BIAS_V)   has_frac = 1'b1;
    else if (ipos >= FW_V) has_frac = 1'b0;
    else                  has_frac = |(frac_f & frac_mask);
  end

  always_comb begin
    verdict_o.unimpl  = (cls_o == CLS_NAN) || (cls_o == CLS_INF) ||
                        (cls_o == CLS_SUB) || range_err;
    verdict_o.inexact = (cls_o == CLS_NORM) && !range_err && has_frac;
  end
endmodule

// File: rtl/cvt_int_screen.sv
module cvt_int_screen
  import cvt_screen_pkg::*;
#(
  parameter int unsigned INT_W   = 64,
  parameter int unsigned LIM_BIT = 55
) (
  input  logic [INT_W-1:0] val_i,
  output verdict_t         verdict_o
);
  localparam int unsigned TOP_W = INT_W - LIM_BIT;

  logic [TOP_W-1:0] top_bits;
  assign top_bits = val_i[INT_W-1:LIM_BIT];

  // in range only when the upper bits are a pure sign extension
  always_comb begin
    verdict_o.unimpl  = !((&top_bits) || (~|top_bits));
    verdict_o.inexact = 1'b0;
  end
endmodule

// File: rtl/cvt_screen.sv
module cvt_screen
  import cvt_screen_pkg::*;
#(
  parameter int unsigned SP_EXP_W   = 8,
  parameter int unsigned SP_FRAC_W  = 23,
  parameter int unsigned SP_LIM_EXP = 31,
  parameter int unsigned DP_EXP_W   = 11,
  parameter int unsigned DP_FRAC_W  = 52,
  parameter int unsigned DP_LIM_EXP = 53,
  parameter int unsigned INT_W      = 64,
  parameter int unsigned INT_LIM    = 55
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       kind_i,
  input  logic [INT_W-1:0] src_i,
  input  logic             inexact_en_i,
  output logic             valid_o,
  output logic [1:0]       cause_o,
  output logic             block_o,
  output logic             flag_inexact_o
);
  localparam int unsigned SP_W = SP_EXP_W + SP_FRAC_W + 1;
  localparam int unsigned DP_W = DP_EXP_W + DP_FRAC_W + 1;

  fp_class_e sp_cls, dp_cls;
  verdict_t  sp_v, dp_v, int_v, sel_v;

  cvt_float_screen #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W), .LIM_EXP(SP_LIM_EXP)) u_sp (
    .val_i     (src_i[SP_W-1:0]),
    .cls_o     (sp_cls),
    .verdict_o (sp_v)
  );

  cvt_float_screen #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W), .LIM_EXP(DP_LIM_EXP)) u_dp (
    .val_i     (src_i[DP_W-1:0]),
    .cls_o     (dp_cls),
    .verdict_o (dp_v)
  );

  cvt_int_screen #(.INT_W(INT_W), .LIM_BIT(INT_LIM)) u_int (
    .val_i     (src_i),
    .verdict_o (int_v)
  );

  always_comb begin
    unique case (src_kind_e'(kind_i))
      KIND_SP: sel_v = sp_v;
      KIND_DP: sel_v = dp_v;
      default: sel_v = int_v;
    endcase
  end

  logic [1:0] cause_d;
  always_comb begin
    cause_d = '0;
    if (sel_v.unimpl)       cause_d[CAUSE_UNI] = 1'b1;
    else if (sel_v.inexact) cause_d[CAUSE_INX] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o        <= 1'b0;
      cause_o        <= '0;
      block_o        <= 1'b0;
      flag_inexact_o <= 1'b0;
    end else begin
      valid_o        <= valid_i;
      cause_o        <= valid_i ? cause_d : 2'b00;
      block_o        <= valid_i && sel_v.unimpl;
      flag_inexact_o <= valid_i && !sel_v.unimpl && sel_v.inexact && !inexact_en_i;
    end
  end
endmodule

// File: rtl/cvt_screen_checker.sv
module cvt_screen_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic [1:0] kind_i,
  input logic       inexact_en_i,
  input logic       valid_o,
  input logic [1:0] cause_o,
  input logic       block_o,
  input logic       flag_inexact_o
);
  assert_valid_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (cause_o == 2'b00 && !block_o && !flag_inexact_o));

  assert_cause_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cause_o));

  assert_block_match_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_o == cause_o[1]);

  assert_flag_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && inexact_en_i) |=> !flag_inexact_o);

  assert_flag_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_inexact_o |-> cause_o[0]);

  assert_int_exact_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i[1]) |=> !cause_o[0]);
endmodule

bind cvt_screen cvt_screen_checker u_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .valid_i        (valid_i),
  .kind_i         (kind_i),
  .inexact_en_i   (inexact_en_i),
  .valid_o        (valid_o),
  .cause_o        (cause_o),
  .block_o        (block_o),
  .flag_inexact_o (flag_inexact_o)
);

// File: tb/cvt_screen_bench.sv
module cvt_screen_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  kind_i = 2'd0;
  logic [63:0] src_i = '0;
  logic        inexact_en_i = 1'b0;
  logic        valid_o;
  logic [1:0]  cause_o;
  logic        block_o;
  logic        flag_inexact_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  cvt_screen u_cvt_screen (
    .clk_i, .rst_ni, .valid_i, .kind_i, .src_i, .inexact_en_i,
    .valid_o, .cause_o, .block_o, .flag_inexact_o
  );

  function automatic void check(string req, logic [63:0] act, logic [63:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endfunction

  // returns {unimpl, inexact}
  function automatic logic [1:0] ref_verdict(logic [1:0] k, logic [63:0] x);
    real r;
    logic [10:0] e;
    if (k[1]) begin
      longint signed v = longint'(x);
      return {(v >= 64'sh0080000000000000) || (v < -64'sh0080000000000000), 1'b0};
    end
    if (k == 2'd0) begin
      if (x[30:23] == 8'hFF || (x[30:23] == 0 && x[22:0] != 0)) return 2'b10;
      if (x[30:0] == 0) return 2'b00;
      e = 11'(x[30:23]) + 11'd896;
      r = $bitstoreal({x[31], e, x[22:0], 29'd0});
      if (r >= 2147483648.0 || r <= -2147483648.0) return 2'b10;
    end else begin
      if (x[62:52] == 11'h7FF || (x[62:52] == 0 && x[51:0] != 0)) return 2'b10;
      if (x[62:0] == 0) return 2'b00;
      r = $bitstoreal(x);
      if (r >= 9007199254740992.0 || r <= -9007199254740992.0) return 2'b10;
    end
    return {1'b0, r != $floor(r)};
  endfunction

  task automatic apply(string req, logic [1:0] k, logic [63:0] x, logic en);
    logic [1:0] v;
    valid_i = 1'b1; kind_i = k; src_i = x; inexact_en_i = en;
    v = ref_verdict(k, x);
    @(negedge clk_i);
    check({req, " valid"}, 64'(valid_o), 64'd1);
    check({req, " cause R10"}, 64'(cause_o), 64'(v[1] ? 2'b10 : {1'b0, v[0]}));
    check({req, " block R10"}, 64'(block_o), 64'(v[1]));
    check({req, " flag R9"}, 64'(flag_inexact_o), 64'(!v[1] && v[0] && !en));
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk_i);
    check("R1 valid", 64'(valid_o), 0);
    check("R1 cause", 64'(cause_o), 0);
    check("R1 block", 64'(block_o), 0);
    check("R1 flag", 64'(flag_inexact_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R3 specials
    apply("R3 sp inf", 2'd0, 64'h7F800000, 0);
    apply("R3 sp nan", 2'd0, 64'hFFC00001, 0);
    apply("R3 sp sub", 2'd0, 64'h00000010, 0);
    apply("R3 dp inf", 2'd1, 64'hFFF0000000000000, 0);
    apply("R3 dp sub", 2'd1, 64'h0000000000000001, 0);
    // R4 zeros
    apply("R4 sp +0", 2'd0, 64'h00000000, 0);
    apply("R4 dp -0", 2'd1, 64'h8000000000000000, 0);
    // R5 single limits
    apply("R5 sp 2^31", 2'd0, 64'h4F000000, 0);
    apply("R5 sp -2^31", 2'd0, 64'hCF000000, 0);
    apply("R5 sp below", 2'd0, 64'h4EFFFFFF, 0);
    // R6 double limits
    apply("R6 dp 2^53", 2'd1, 64'h4340000000000000, 0);
    apply("R6 dp -2^53", 2'd1, 64'hC340000000000000, 0);
    apply("R6 dp below", 2'd1, 64'h433FFFFFFFFFFFFF, 0);
    // R7 / R11 integer limits
    apply("R7 int 2^55", 2'd2, 64'h0080000000000000, 0);
    apply("R7 int -2^55", 2'd3, 64'hFF80000000000000, 0);
    apply("R7 int -2^55-1", 2'd2, 64'hFF7FFFFFFFFFFFFF, 0);
    apply("R11 int max", 2'd2, 64'h007FFFFFFFFFFFFF, 0);
    // R8 / R9 fractions
    apply("R8 sp 1.5", 2'd0, 64'h3FC00000, 0);
    apply("R9 sp 1.5 en", 2'd0, 64'h3FC00000, 1);
    apply("R8 sp 0.5", 2'd0, 64'h3F000000, 0);
    apply("R8 sp 3.0", 2'd0, 64'h40400000, 0);
    apply("R8 dp -2.25", 2'd1, 64'hC002000000000000, 0);
    apply("R8 dp 2^52+1", 2'd1, 64'h4330000000000001, 0);
    // R2 idle
    valid_i = 1'b0;
    @(negedge clk_i);
    check("R2 idle valid", 64'(valid_o), 0);
    check("R2 idle cause", 64'(cause_o), 0);
    // random
    for (int i = 0; i < 400; i++) begin
      logic [63:0] x;
      logic [1:0]  k = 2'($urandom % 4);
      x = {$urandom, $urandom};
      if (k == 2'd0) x = {32'd0, x[31], 8'(100 + $urandom % 70), x[22:0]};
      else if (k == 2'd1) x = {x[63], 11'(1000 + $urandom % 90), x[51:0]};
      else x = 64'($signed(x) >>> ($urandom % 20));
      apply("R8 random", k, x, 1'($urandom));
    end
    valid_i = 1'b0;
    @(negedge clk_i);
    check("R2 tail", 64'(valid_o), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule